// File: doc/BRIEF.md
# Supervisor Call Request and Vector Fetch Steering

This block sits between a small 32-bit CPU's AHB-Lite address path and the memory map. It holds a supervisor-call request register. A write to that register with the top bit high, made while the core is not already servicing an NMI, raises a one-cycle NMI pulse to the core. The same write captures the call number and which bus master issued it, grants access to the hidden boot ROM, and forces the two reset-vector words to be read from that ROM. A separate argument register holds a pointer to the call's parameter block.

Incoming fetch addresses are steered combinationally to one of three places:
- the ROM, while the ROM-vector bit is set and the address lies in the first eight bytes;
- RAM, while the vector-in-RAM configuration bit is set and the address lies inside the vector table window;
- unchanged to flash in every other case.

The privileged status bit drives HPROT[1] on every access, so downstream slaves can fence off privileged-only registers.

Top module: `svc_vec_ctrl`

## Requirements
- R1: After reset all three registers read zero, `nmi_o` is low, `hprot1_o` is low and `mem_haddr_o` equals `cpu_haddr_i`.
- R2: A write to the request register (offset 0x4) with bit 31 high while `cpu_in_nmi_i` is low raises `nmi_o` for exactly the one cycle after the write edge, and sets request bit 31.
- R3: A request write with bit 31 high while `cpu_in_nmi_i` is high raises no NMI and leaves bit 31, the master bit and the call number unchanged. Its bit 30 and bit 28 are still taken.
- R4: ROM-access-enable (bit 29) is set only by an accepted request. A software write of bit 29 has no effect on it.
- R5: On an accepted request, the master bit (bit 27) becomes 0 when `reg_dbg_i` is low (CPU) and 1 when it is high (debug port).
- R6: An accepted request captures bits 7:0 as the call number. The argument register at offset 0x8 (request + 4) holds a full 32-bit pointer.
- R7: An accepted request sets the ROM-vector bit (bit 30). While it is set, addresses 0x0 to 0x7 map to `ROM_BASE` plus the address, and address 0x8 passes through.
- R8: While configuration bit 0 (offset 0x0) is set, addresses below `VTAB_BYTES` map to `RAM_BASE` plus the address. Address `VTAB_BYTES` passes through.
- R9: When both redirects apply to an address, the ROM wins.
- R10: `hprot1_o` follows the privileged bit (bit 28) of the request register.
- R11: A request write with bit 31 low clears bit 31 and bit 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_dbg_i | input | 1 | Write comes from the debug port |
| reg_waddr_i | input | 4 | Write byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 4 | Read byte offset |
| reg_rdata_o | output | 32 | Read data (combinational) |
| cpu_in_nmi_i | input | 1 | Core is executing an NMI handler |
| nmi_o | output | 1 | NMI pulse to the core |
| cpu_haddr_i | input | 32 | Fetch address from the core |
| mem_haddr_o | output | 32 | Steered address to the memory map |
| hprot1_o | output | 1 | Privilege bit for the bus |

## Verification
The assertions assume that `cpu_in_nmi_i` and `reg_dbg_i` are stable across a write cycle. They also assume that each write strobe lasts a single cycle, with its address and data valid in that cycle. The stimulus changes these inputs only shortly after a rising edge. It raises `reg_wr_i` for exactly one cycle per write and sets `cpu_in_nmi_i` before the write it is meant to qualify. Fetch addresses are applied only while no register write is pending, so every steering check sees settled register state.

// File: rtl/svc_vec_pkg.sv
// Package: shared offsets, field positions and the status record for the
// supervisor-call controller. Assumes 4-bit byte offsets on the register port.
package svc_vec_pkg;
    localparam int OFS_W     = 4;
    localparam logic [OFS_W-1:0] OFS_CFG = 4'h0;
    localparam logic [OFS_W-1:0] OFS_REQ = 4'h4;
    localparam logic [OFS_W-1:0] OFS_ARG = 4'h8;

    localparam int B_REQ    = 31;
    localparam int B_ROMVEC = 30;
    localparam int B_ROMACC = 29;
    localparam int B_PRIV   = 28;
    localparam int B_MASTER = 27;
    localparam int CALL_W   = 8;

    typedef struct packed {
        logic              req;
        logic              romvec;
        logic              romacc;
        logic              priv;
        logic              master;
        logic [CALL_W-1:0] callno;
    } svc_stat_t;
endpackage

// File: rtl/svc_regs.sv
// Register file: configuration, request/status and argument registers.
// Decides whether a request write is accepted and emits the NMI pulse.
// Assumes one-cycle write strobes and a stable cpu_in_nmi_i during them.
module svc_regs
    import svc_vec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             dbg_i,
    input  logic [OFS_W-1:0] waddr_i,
    input  logic [31:0]      wdata_i,
    input  logic             in_nmi_i,
    input  logic [OFS_W-1:0] raddr_i,
    output logic [31:0]      rdata_o,
    output svc_stat_t        stat_o,
    output logic             vec_ram_o,
    output logic             nmi_o
);
    svc_stat_t   stat_q;
    logic        ram_q;
    logic [31:0] arg_q;
    logic        nmi_q;
    logic        req_wr, accept, give_back;

    // Purpose: classify a write to the request register
    always_comb begin
        req_wr    = wr_i && (waddr_i == OFS_REQ);
        accept    = req_wr && wdata_i[B_REQ] && !in_nmi_i;
        give_back = req_wr && !wdata_i[B_REQ];
    end

    // Purpose: update the status fields on entry, return or in-NMI writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (accept) begin
            stat_q.req    <= 1'b1;
            stat_q.romvec <= 1'b1;
            stat_q.romacc <= 1'b1;
            stat_q.priv   <= wdata_i[B_PRIV];
            stat_q.master <= dbg_i;
            stat_q.callno <= wdata_i[CALL_W-1:0];
        end else if (give_back) begin
            stat_q.req    <= 1'b0;
            stat_q.romacc <= 1'b0;
            stat_q.romvec <= wdata_i[B_ROMVEC];
            stat_q.priv   <= wdata_i[B_PRIV];
        end else if (req_wr) begin
            stat_q.romvec <= wdata_i[B_ROMVEC];
            stat_q.priv   <= wdata_i[B_PRIV];
        end
    end

    // Purpose: configuration and argument registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_q <= 1'b0;
            arg_q <= '0;
        end else if (wr_i) begin
            if (waddr_i == OFS_CFG) ram_q <= wdata_i[0];
            if (waddr_i == OFS_ARG) arg_q <= wdata_i;
        end
    end

    // Purpose: one-cycle NMI pulse per accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= accept;
    end

    // Purpose: read multiplexer
    always_comb begin
        rdata_o = '0;
        unique case (raddr_i)
            OFS_CFG: rdata_o[0] = ram_q;
            OFS_REQ: begin
                rdata_o[B_REQ]        = stat_q.req;
                rdata_o[B_ROMVEC]     = stat_q.romvec;
                rdata_o[B_ROMACC]     = stat_q.romacc;
                rdata_o[B_PRIV]       = stat_q.priv;
                rdata_o[B_MASTER]     = stat_q.master;
                rdata_o[CALL_W-1:0]   = stat_q.callno;
            end
            OFS_ARG: rdata_o = arg_q;
            default: rdata_o = '0;
        endcase
    end

    assign stat_o    = stat_q;
    assign vec_ram_o = ram_q;
    assign nmi_o     = nmi_q;
endmodule

// File: rtl/vec_steer.sv
// Address steering: maps vector-table fetches to ROM, RAM or leaves them for
// flash. ROM redirect wins over RAM redirect. Purely combinational.
module vec_steer #(
    parameter logic [31:0] ROM_BASE   = 32'h1000_0000,
    parameter logic [31:0] RAM_BASE   = 32'h2000_0000,
    parameter int          ROM_BYTES  = 8,
    parameter int          VTAB_BYTES = 192
) (
    input  logic        romvec_i,
    input  logic        vec_ram_i,
    input  logic [31:0] addr_i,
    output logic [31:0] addr_o
);
    localparam logic [31:0] ROM_LIM = 32'(ROM_BYTES);
    localparam logic [31:0] TAB_LIM = 32'(VTAB_BYTES);

    logic hit_rom, hit_ram;

    // Purpose: pick the target region for the current address
    always_comb begin
        hit_rom = romvec_i  && (addr_i < ROM_LIM);
        hit_ram = vec_ram_i && (addr_i < TAB_LIM);
        if (hit_rom)      addr_o = ROM_BASE | addr_i;
        else if (hit_ram) addr_o = RAM_BASE | addr_i;
        else              addr_o = addr_i;
    end
endmodule

// File: rtl/svc_vec_ctrl.sv
// Top: supervisor-call request register plus vector fetch steering.
// Assumes bases aligned above the vector table window.
module svc_vec_ctrl
    import svc_vec_pkg::*;
#(
    parameter logic [31:0] ROM_BASE   = 32'h1000_0000,
    parameter logic [31:0] RAM_BASE   = 32'h2000_0000,
    parameter int          VTAB_BYTES = 192
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_i,
    input  logic        reg_dbg_i,
    input  logic [3:0]  reg_waddr_i,
    input  logic [31:0] reg_wdata_i,
    input  logic [3:0]  reg_raddr_i,
    output logic [31:0] reg_rdata_o,
    input  logic        cpu_in_nmi_i,
    output logic        nmi_o,
    input  logic [31:0] cpu_haddr_i,
    output logic [31:0] mem_haddr_o,
    output logic        hprot1_o
);
    svc_stat_t stat;
    logic      vec_ram;
    logic      st_req, st_romvec, st_romacc;

    svc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .dbg_i     (reg_dbg_i),
        .waddr_i   (reg_waddr_i),
        .wdata_i   (reg_wdata_i),
        .in_nmi_i  (cpu_in_nmi_i),
        .raddr_i   (reg_raddr_i),
        .rdata_o   (reg_rdata_o),
        .stat_o    (stat),
        .vec_ram_o (vec_ram),
        .nmi_o     (nmi_o)
    );

    vec_steer #(
        .ROM_BASE   (ROM_BASE),
        .RAM_BASE   (RAM_BASE),
        .ROM_BYTES  (8),
        .VTAB_BYTES (VTAB_BYTES)
    ) u_steer (
        .romvec_i  (stat.romvec),
        .vec_ram_i (vec_ram),
        .addr_i    (cpu_haddr_i),
        .addr_o    (mem_haddr_o)
    );

    // Purpose: expose status for the privilege line and the checker
    assign hprot1_o  = stat.priv;
    assign st_req    = stat.req;
    assign st_romvec = stat.romvec;
    assign st_romacc = stat.romacc;
endmodule

// File: rtl/svc_vec_chk.sv
// Checker for svc_vec_ctrl: protocol properties on NMI, status and steering.
module svc_vec_chk #(
    parameter logic [31:0] ROM_BASE = 32'h1000_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_i,
    input logic [3:0]  reg_waddr_i,
    input logic [31:0] reg_wdata_i,
    input logic        cpu_in_nmi_i,
    input logic        nmi_o,
    input logic [31:0] cpu_haddr_i,
    input logic [31:0] mem_haddr_o,
    input logic        hprot1_o,
    input logic        st_req,
    input logic        st_romvec,
    input logic        st_romacc
);
    logic go;
    // Purpose: accepted request as seen from the ports
    assign go = reg_wr_i && reg_waddr_i == 4'h4 && reg_wdata_i[31] && !cpu_in_nmi_i;

    p_nmi_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> $past(go));
    p_nmi_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (nmi_o && st_req));
    p_nmi_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_waddr_i == 4'h4 && reg_wdata_i[31] && cpu_in_nmi_i) |=> !nmi_o);
    p_romacc_hw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_romacc) |-> $past(go));
    p_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_waddr_i == 4'h4 && !reg_wdata_i[31]) |=> (!st_req && !st_romacc));
    p_priv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_waddr_i == 4'h4 && !(reg_wdata_i[31] && !cpu_in_nmi_i))
        |=> hprot1_o == $past(reg_wdata_i[28]));
    p_romvec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_romvec && cpu_haddr_i < 32'd8) |-> mem_haddr_o == (ROM_BASE | cpu_haddr_i));
endmodule

bind svc_vec_ctrl svc_vec_chk #(.ROM_BASE(ROM_BASE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_i     (reg_wr_i),
    .reg_waddr_i  (reg_waddr_i),
    .reg_wdata_i  (reg_wdata_i),
    .cpu_in_nmi_i (cpu_in_nmi_i),
    .nmi_o        (nmi_o),
    .cpu_haddr_i  (cpu_haddr_i),
    .mem_haddr_o  (mem_haddr_o),
    .hprot1_o     (hprot1_o),
    .st_req       (st_req),
    .st_romvec    (st_romvec),
    .st_romacc    (st_romacc)
);

// File: tb/sim_svc_vec_ctrl.sv
// Scoreboard bench: driver pushes expectations, monitor compares at negedge.
module sim_svc_vec_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_i = 1'b0, reg_dbg_i = 1'b0, cpu_in_nmi_i = 1'b0;
    logic [3:0]  reg_waddr_i = '0, reg_raddr_i = '0;
    logic [31:0] reg_wdata_i = '0, cpu_haddr_i = '0;
    logic [31:0] reg_rdata_o, mem_haddr_o;
    logic        nmi_o, hprot1_o;

    typedef struct {
        string       tag;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    svc_vec_ctrl u0 (.*);

    // Monitor: pop every pending expectation and compare it with the output
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.sel)
                    0: act = reg_rdata_o;
                    1: act = {31'd0, nmi_o};
                    2: act = mem_haddr_o;
                    default: act = {31'd0, hprot1_o};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic expect_v(string tag, int sel, logic [31:0] e);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = e;
        q.push_back(it);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, logic dbg);
        reg_wr_i = 1'b1; reg_waddr_i = a; reg_wdata_i = d; reg_dbg_i = dbg;
        step();
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(string tag, logic [3:0] a, logic [31:0] e);
        reg_raddr_i = a;
        expect_v(tag, 0, e);
        step();
    endtask

    task automatic fetch(string tag, logic [31:0] a, logic [31:0] e);
        cpu_haddr_i = a;
        expect_v(tag, 2, e);
        step();
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        rd("R1 cfg", 4'h0, 32'h0);
        rd("R1 req", 4'h4, 32'h0);
        rd("R1 arg", 4'h8, 32'h0);
        expect_v("R1 nmi", 1, 32'h0);
        expect_v("R1 hprot", 3, 32'h0);
        fetch("R1 passthrough", 32'h4, 32'h4);

        // R2 R4 R5 R6 R7: CPU request
        wr(4'h4, 32'h8000_0012, 1'b0);
        expect_v("R2 nmi pulse", 1, 32'h1);
        step();
        expect_v("R2 nmi one cycle", 1, 32'h0);
        rd("R2 R4 R5 R6 status", 4'h4, 32'hE000_0012);
        fetch("R7 rom word", 32'h4, 32'h1000_0004);
        fetch("R7 edge pass", 32'h8, 32'h8);

        // R3 R10: write while in NMI
        cpu_in_nmi_i = 1'b1;
        wr(4'h4, 32'h9000_0055, 1'b1);
        expect_v("R3 no nmi", 1, 32'h0);
        step();
        rd("R3 status kept", 4'h4, 32'hB000_0012);
        expect_v("R10 hprot high", 3, 32'h1);
        step();

        // R11 R4: return write tries to set bit 29
        wr(4'h4, 32'h2000_0000, 1'b0);
        rd("R11 return clears", 4'h4, 32'h0000_0012);
        expect_v("R10 hprot low", 3, 32'h0);
        step();
        cpu_in_nmi_i = 1'b0;
        wr(4'h4, 32'h2000_0000, 1'b0);
        rd("R4 sw cannot set", 4'h4, 32'h0000_0012);

        // R5: debug-port request
        wr(4'h4, 32'h8000_00A5, 1'b1);
        expect_v("R5 nmi dbg", 1, 32'h1);
        step();
        rd("R5 master dbg", 4'h4, 32'hE800_00A5);

        // R6: argument register
        wr(4'h8, 32'h2000_0100, 1'b0);
        rd("R6 arg", 4'h8, 32'h2000_0100);

        // R8: RAM redirect
        wr(4'h4, 32'h0, 1'b0);
        wr(4'h0, 32'h1, 1'b0);
        rd("R8 cfg", 4'h0, 32'h1);
        fetch("R8 ram", 32'h10, 32'h2000_0010);
        fetch("R8 ram low", 32'h4, 32'h2000_0004);
        fetch("R8 window end", 32'hC0, 32'hC0);

        // R9: both redirects
        wr(4'h4, 32'h4000_0000, 1'b0);
        fetch("R9 rom wins", 32'h4, 32'h1000_0004);
        fetch("R9 ram beyond", 32'h8, 32'h2000_0008);
        step();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #200000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule